// File: doc/BRIEF.md
# Key-Guarded Peripheral Enable Controller

This block sits on a simple memory-mapped register bus and decides which of a set of peripherals are switched on. Changing the enable pattern is a two-step act. Software first stores a fixed 32-bit magic value into a lock register. That opens a short window, counted in clock cycles, during which exactly one write to the enable register is honoured.

Each bit of the enable register drives a small state machine for one peripheral. Turning a peripheral on is not instant: it spends a fixed number of cycles in an enable-in-progress state before it reports enabled. Turning it off takes effect on the next cycle. A read-only status register packs a 3-bit state code for every peripheral, so software can poll it until the change has settled.

Peripherals that are powered down at build time report a static-powerdown code and ignore their enable bit. One enable output per peripheral is high only while that peripheral is fully enabled.

Top module: `periph_gate_ctrl`

## Requirements
- R1: A write of exactly 0x0F0A0B00 to the lock register (word address 0) opens the write window. A read of address 0 returns 1 in bit 0 while the window is open and 0 otherwise.
- R2: An open window accepts exactly one write to the enable register (word address 1) and then closes. Further enable-register writes are ignored until the key is written again.
- R3: An enable-register write is accepted when it lands on the 1st through the 16th clock edge after the edge that captured the key. If no write arrives, the window closes at the 16th edge.
- R4: A lock-register write of any other value closes an open window at once and never opens one.
- R5: Enable-register bits [7:0] hold one enable request per peripheral, with bit i for peripheral i. A read of address 1 returns the stored value zero-extended.
- R6: The status register (word address 2) is read-only, and writes to it have no effect. Peripheral i reports its state in bits [3i+2:3i] with these codes: 000 disabled, 001 enabled, 010 static powerdown, 011 enable in progress, 100 reset. Unused bits read 0.
- R7: Setting a peripheral's enable bit moves it to enable-in-progress on the next edge. It stays there for exactly 4 cycles and then reports enabled. Its enable output is high only in the enabled state.
- R8: Clearing a peripheral's enable bit moves it to disabled on the next edge, whether it was enabled or still enabling.
- R9: Reset does four things: every peripheral reports the reset code, the window closes, the enable register clears, and all enable outputs go low. Once reset is released, each peripheral leaves the reset code on its first clock edge.
- R10: Peripherals selected by the static-powerdown mask (default: peripheral 7) report 010 after reset and never raise their enable output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Word address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational from register state |
| periph_en | output | 8 | Per-peripheral enable, high only while that peripheral is enabled |

## Verification
A window timer that is off by one shows up at the boundary edges. It would accept a write on the 17th edge, or refuse one on the 16th, and the enable-register readback would disagree on the very next read. A one-shot flag that fails to clear lets a second write change the readback at once. A per-peripheral state machine with a wrong ramp count shows an enable code one cycle early or late in the status word and on periph_en. A wrong disable path leaves code 011 or 001 visible one edge after the request.

// File: rtl/periph_gate_pkg.sv
package periph_gate_pkg;

  typedef enum logic [2:0] {
    PST_OFF  = 3'b000,
    PST_ON   = 3'b001,
    PST_SPD  = 3'b010,
    PST_BUSY = 3'b011,
    PST_RST  = 3'b100
  } pstate_e;

  localparam int unsigned PST_W = 3;

  localparam logic [3:0] REG_LOCK   = 4'h0;
  localparam logic [3:0] REG_ENABLE = 4'h1;
  localparam logic [3:0] REG_STATUS = 4'h2;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign srst_n = pipe_q[STAGES-1];

endmodule

// File: rtl/key_window.sv
module key_window #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 32'h0F0A0B00,
  parameter int unsigned WINDOW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_we,
  input  logic [DATA_W-1:0] lock_wdata,
  input  logic              cfg_we,
  output logic              win_open,
  output logic              cfg_accept
);

  localparam int unsigned CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

  logic             open_q, open_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;
  logic             key_hit;

  assign key_hit = lock_we && (lock_wdata == KEY);
  assign upd_en  = lock_we || open_q;

  always_comb begin
    open_d = open_q;
    cnt_d  = cnt_q;
    if (lock_we) begin
      open_d = key_hit;
      cnt_d  = '0;
    end else if (open_q) begin
      if (cfg_we || (cnt_q == LAST)) begin
        open_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      open_q <= open_d;
      cnt_q  <= cnt_d;
    end
  end

  assign win_open   = open_q;
  assign cfg_accept = cfg_we && open_q && !lock_we;

  // R1
  key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> win_open);

  // R4
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_we && !key_hit) |=> !win_open);

  // R2
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_accept |=> !win_open);

  // R3
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> (cnt_q <= LAST));

endmodule

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int unsigned N_PERIPH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [N_PERIPH-1:0] wdata,
  output logic [N_PERIPH-1:0] cfg
);

  logic [N_PERIPH-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = accept ? wdata : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (accept) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(cfg_q));

endmodule

// File: rtl/periph_fsm.sv
module periph_fsm
  import periph_gate_pkg::*;
#(
  parameter int unsigned RAMP = 4,
  parameter bit STATIC_PD = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_req,
  output logic [PST_W-1:0] code,
  output logic             en_out
);

  localparam int unsigned CNT_W = $clog2(RAMP + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RAMP - 1);

  pstate_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (STATIC_PD) begin
      st_d  = PST_SPD;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        PST_RST, PST_OFF: begin
          cnt_d = '0;
          st_d  = en_req ? PST_BUSY : PST_OFF;
        end
        PST_BUSY: begin
          if (!en_req) begin
            st_d  = PST_OFF;
            cnt_d = '0;
          end else if (cnt_q == LAST) begin
            st_d  = PST_ON;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PST_ON: begin
          cnt_d = '0;
          if (!en_req) st_d = PST_OFF;
        end
        default: begin
          st_d  = PST_OFF;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PST_RST;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign code   = st_q;
  assign en_out = (st_q == PST_ON);

  // R8
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_req && !STATIC_PD) |=> (st_q == PST_OFF));

  // R7
  ramp_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_out) |-> ($past(st_q) == PST_BUSY));

  // R10
  static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    STATIC_PD |=> (st_q == PST_SPD) && !en_out);

endmodule

// File: rtl/periph_gate_ctrl.sv
module periph_gate_ctrl
  import periph_gate_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_PERIPH = 8,
  parameter int unsigned WINDOW = 16,
  parameter int unsigned RAMP = 4,
  parameter logic [DATA_W-1:0] KEY = 32'h0F0A0B00,
  parameter logic [N_PERIPH-1:0] STATIC_PD_MASK = 8'h80
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [N_PERIPH-1:0] periph_en
);

  localparam int unsigned STAT_W = N_PERIPH * PST_W;

  logic                rst_n_s;
  logic                lock_we, cfg_we;
  logic                win_open, cfg_accept;
  logic [N_PERIPH-1:0] cfg;
  logic [STAT_W-1:0]   status;

  rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_n_s)
  );

  assign lock_we = bus_we && (bus_addr == ADDR_W'(REG_LOCK));
  assign cfg_we  = bus_we && (bus_addr == ADDR_W'(REG_ENABLE));

  key_window #(.DATA_W(DATA_W), .KEY(KEY), .WINDOW(WINDOW)) u_win (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .lock_we    (lock_we),
    .lock_wdata (bus_wdata),
    .cfg_we     (cfg_we),
    .win_open   (win_open),
    .cfg_accept (cfg_accept)
  );

  cfg_store #(.N_PERIPH(N_PERIPH)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .accept (cfg_accept),
    .wdata  (bus_wdata[N_PERIPH-1:0]),
    .cfg    (cfg)
  );

  for (genvar g = 0; g < N_PERIPH; g++) begin : g_periph
    periph_fsm #(.RAMP(RAMP), .STATIC_PD(STATIC_PD_MASK[g])) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .en_req (cfg[g]),
      .code   (status[g*PST_W +: PST_W]),
      .en_out (periph_en[g])
    );
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(REG_LOCK):   bus_rdata = DATA_W'(win_open);
      ADDR_W'(REG_ENABLE): bus_rdata = DATA_W'(cfg);
      ADDR_W'(REG_STATUS): bus_rdata = DATA_W'(status);
      default:             bus_rdata = '0;
    endcase
  end

  // R6
  status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_we && bus_addr == ADDR_W'(REG_STATUS) && !cfg_accept) |=> $stable(cfg));

endmodule

// File: tb/tb_periph_gate_ctrl.sv
`timescale 1ns/1ps
module tb_periph_gate_ctrl;

  localparam logic [31:0] KEY = 32'h0F0A0B00;
  localparam logic [3:0] A_LOCK = 4'h0, A_EN = 4'h1, A_ST = 4'h2;
  localparam logic [3:0] K_PEN = 4'hF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  periph_en;

  typedef struct {
    logic [3:0]  kind;
    logic [31:0] exp;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 0;

  always #4 clk = ~clk;

  periph_gate_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .periph_en (periph_en)
  );

  // monitor: pops expected items and compares against the ports
  always begin
    @(chk_ev);
    while (exp_q.size() > 0) begin
      exp_t it;
      logic [31:0] act;
      it  = exp_q.pop_front();
      act = (it.kind == K_PEN) ? 32'(periph_en) : bus_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s: kind %0h actual %h expected %h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_reg(input logic [3:0] kind, input logic [31:0] exp, input string req);
    exp_t it;
    if (kind != K_PEN) bus_addr = kind;
    it.kind = kind; it.exp = exp; it.req = req;
    exp_q.push_back(it);
    #0.5;
    ->chk_ev;
    #0.5;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    idle(3);
    expect_reg(A_ST, 32'h00924924, "R9 reset code");
    expect_reg(A_EN, 32'h0, "R9 enable cleared");
    expect_reg(A_LOCK, 32'h0, "R9 window closed");
    rst_n = 1'b1;
    idle(5);
    expect_reg(A_ST, 32'h00400000, "R9 disabled after reset / R10 static");
    expect_reg(K_PEN, 32'h0, "R9 enables low");

    // write without key is ignored
    wr(A_EN, 32'hFF);
    idle(1);
    expect_reg(A_EN, 32'h0, "R2 no key ignored");
    expect_reg(A_ST, 32'h00400000, "R2 status unchanged");

    // key then write 0x05
    wr(A_LOCK, KEY);
    expect_reg(A_LOCK, 32'h1, "R1 window open");
    wr(A_EN, 32'h05);
    expect_reg(A_EN, 32'h05, "R5 readback");
    expect_reg(A_LOCK, 32'h0, "R2 closed after accept");
    idle(1);
    expect_reg(A_ST, 32'h004000C3, "R7 in progress");
    idle(3);
    expect_reg(A_ST, 32'h004000C3, "R7 still in progress at 4th cycle");
    expect_reg(K_PEN, 32'h0, "R7 enable low while ramping");
    idle(1);
    expect_reg(A_ST, 32'h00400041, "R7 enabled");
    expect_reg(K_PEN, 32'h05, "R7 enable outputs");

    // second write without new key
    wr(A_EN, 32'hFF);
    expect_reg(A_EN, 32'h05, "R2 second write ignored");

    // write on 16th edge accepted
    wr(A_LOCK, KEY);
    idle(15);
    wr(A_EN, 32'h84);
    expect_reg(A_EN, 32'h84, "R3 16th edge accepted");
    idle(1);
    expect_reg(A_ST, 32'h00400040, "R8 disable next cycle");
    idle(6);
    expect_reg(K_PEN, 32'h04, "R10 masked peripheral never enabled");

    // write on 17th edge rejected
    wr(A_LOCK, KEY);
    idle(15);
    expect_reg(A_LOCK, 32'h1, "R3 open before 16th edge");
    idle(1);
    expect_reg(A_LOCK, 32'h0, "R3 closed after 16th edge");
    wr(A_EN, 32'h00);
    expect_reg(A_EN, 32'h84, "R3 17th edge rejected");

    // wrong key closes, never opens
    wr(A_LOCK, 32'h0F0A0B01);
    expect_reg(A_LOCK, 32'h0, "R4 wrong key does not open");
    wr(A_LOCK, KEY);
    wr(A_ST, 32'h0);
    expect_reg(A_LOCK, 32'h1, "R6 status write leaves window");
    expect_reg(A_ST, 32'h00400040, "R6 status write ignored");
    wr(A_LOCK, 32'hFFFFFFFF);
    expect_reg(A_LOCK, 32'h0, "R4 wrong key closes");
    wr(A_EN, 32'h00);
    expect_reg(A_EN, 32'h84, "R4 write after wrong key ignored");

    // disable while enabling
    wr(A_LOCK, KEY);
    wr(A_EN, 32'h06);
    idle(1);
    expect_reg(A_ST, 32'h00400058, "R7 p1 in progress");
    wr(A_LOCK, KEY);
    wr(A_EN, 32'h04);
    idle(1);
    expect_reg(A_ST, 32'h00400040, "R8 abort from in progress");
    idle(6);
    expect_reg(K_PEN, 32'h04, "R8 p1 stays off");

    // reset in the middle of operation
    wr(A_LOCK, KEY);
    rst_n = 1'b0;
    #1;
    expect_reg(A_ST, 32'h00924924, "R9 reset code mid-run");
    expect_reg(A_LOCK, 32'h0, "R9 window closed by reset");
    expect_reg(A_EN, 32'h0, "R9 enable cleared mid-run");
    expect_reg(K_PEN, 32'h0, "R9 outputs low");
    idle(2);
    rst_n = 1'b1;
    idle(5);
    expect_reg(A_ST, 32'h00400000, "R9 disabled after second reset");
    expect_reg(4'h7, 32'h0, "R6 unmapped reads zero");

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule